// File: doc/BRIEF.md
# GHASH Hash Subkey Pre-Shift Unit

This block prepares a raw 128-bit GHASH hash subkey for a Montgomery-style GF(2^128) multiplier. The multiplier expects the key already multiplied by x, in bit-reflected form. This block produces that form in one clock. The key arrives as two 64-bit words under a valid/ready handshake. The word that comes first in memory becomes the upper half of the 128-bit value and the second word becomes the lower half. This swap absorbs the byte-order change between the memory image and the multiplier's operand layout.

The assembled value is shifted left by one bit across the word boundary. If a one falls out of the top bit, a fixed two-word reduction constant is XORed into the whole result. Because the field polynomial has degree 128, at most one bit can leave the top. No further reduction is ever needed. The conditioned key is held in a register and announced by a single-cycle done pulse.

Top module: `hkey_prep`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_hi`, `out_lo` and `out_done` are all cleared to zero by that edge.
- R2: `in_ready` is high whenever `rst` is low. A key is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- R3: `out_done` is high for exactly the one cycle that follows an accepting edge. It is low after every edge that accepts nothing.
- R4: Word order is swapped: `in_first` forms bits 127:64 of the working value, and `in_second` forms bits 63:0.
- R5: The working value is shifted left by one bit. Bit 63 of `in_second` lands in bit 0 of `out_hi`, and bit 0 of `out_lo` starts as zero.
- R6: When bit 63 of `in_first` is one, the result is XORed with the constant whose high word is 0xC200000000000000 and whose low word is 0x0000000000000001.
- R7: When bit 63 of `in_first` is zero, the shifted value is presented unchanged, with no reduction applied.
- R8: On edges that accept nothing, `out_hi` and `out_lo` keep their previous values, whatever data is on the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Key words on the inputs are valid |
| in_ready | output | 1 | Block can accept a key this cycle |
| in_first | input | 64 | Key word stored first in memory; becomes the upper half |
| in_second | input | 64 | Key word stored second in memory; becomes the lower half |
| out_hi | output | 64 | Upper 64 bits of the conditioned key |
| out_lo | output | 64 | Lower 64 bits of the conditioned key |
| out_done | output | 1 | One-cycle pulse: the conditioned key was just updated |

## Verification
The bench walks a single one through every bit of both input words. This exposes any misplaced boundary bit from a shift that drops or duplicates bit 63 of the lower word. It also exposes a swapped word order, which would show the walking bit in the wrong output half. Vectors with and without the top bit set separate the folded path from the plain path. A design that tested the wrong carry bit, or folded only one word of the constant, would miss bit 0 of the low word or bits 63, 62 and 57 of the high word. Idle cycles carrying changed input data, and a reset applied mid-run, catch outputs that follow the inputs without a handshake and a done flag that lingers past one cycle.

// File: rtl/hkey_prep_pkg.sv
package hkey_prep_pkg;
    localparam int unsigned HKEY_WORD_W = 64;
    // reduction constant, one word per half of the key
    localparam logic [HKEY_WORD_W-1:0] HKEY_FOLD_HI = 64'hC200_0000_0000_0000;
    localparam logic [HKEY_WORD_W-1:0] HKEY_FOLD_LO = 64'h0000_0000_0000_0001;
endpackage

// File: rtl/hkey_swap_shift.sv
module hkey_swap_shift #(
    parameter int unsigned WORD_W = 64
) (
    input  logic [WORD_W-1:0] first_w,
    input  logic [WORD_W-1:0] second_w,
    output logic [WORD_W-1:0] shl_hi,
    output logic [WORD_W-1:0] shl_lo,
    output logic              carry_out
);
    localparam int unsigned NWORDS = 2;

    logic [WORD_W-1:0] word_in  [NWORDS];
    logic [WORD_W-1:0] word_out [NWORDS];

    // swap: the word stored first becomes the upper half
    assign word_in[0] = second_w;
    assign word_in[1] = first_w;

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        if (g == 0) begin : g_bottom
            assign word_out[g] = {word_in[g][WORD_W-2:0], 1'b0};
        end else begin : g_upper
            assign word_out[g] = {word_in[g][WORD_W-2:0], word_in[g-1][WORD_W-1]};
        end
    end

    assign shl_hi    = word_out[1];
    assign shl_lo    = word_out[0];
    assign carry_out = word_in[NWORDS-1][WORD_W-1];
endmodule

// File: rtl/hkey_fold.sv
module hkey_fold #(
    parameter int unsigned      WORD_W  = 64,
    parameter logic [WORD_W-1:0] FOLD_HI = '0,
    parameter logic [WORD_W-1:0] FOLD_LO = '0
) (
    input  logic [WORD_W-1:0] val_hi,
    input  logic [WORD_W-1:0] val_lo,
    input  logic              fold_en,
    output logic [WORD_W-1:0] res_hi,
    output logic [WORD_W-1:0] res_lo
);
    localparam int unsigned NWORDS = 2;

    logic [WORD_W-1:0] val_w  [NWORDS];
    logic [WORD_W-1:0] res_w  [NWORDS];
    logic [WORD_W-1:0] poly_w [NWORDS];

    assign val_w[0]  = val_lo;
    assign val_w[1]  = val_hi;
    assign poly_w[0] = FOLD_LO;
    assign poly_w[1] = FOLD_HI;

    // the single carry out of the top selects the whole constant
    for (genvar g = 0; g < NWORDS; g++) begin : g_fold
        assign res_w[g] = val_w[g] ^ (poly_w[g] & {WORD_W{fold_en}});
    end

    assign res_hi = res_w[1];
    assign res_lo = res_w[0];
endmodule

// File: rtl/hkey_prep.sv
module hkey_prep
    import hkey_prep_pkg::*;
#(
    parameter int unsigned       WORD_W  = HKEY_WORD_W,
    parameter logic [WORD_W-1:0] FOLD_HI = HKEY_FOLD_HI,
    parameter logic [WORD_W-1:0] FOLD_LO = HKEY_FOLD_LO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_first,
    input  logic [WORD_W-1:0] in_second,
    output logic [WORD_W-1:0] out_hi,
    output logic [WORD_W-1:0] out_lo,
    output logic              out_done
);
    typedef struct packed {
        logic              done;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } prep_state_t;

    prep_state_t state_d, state_q;

    logic [WORD_W-1:0] shl_hi, shl_lo;
    logic [WORD_W-1:0] cond_hi, cond_lo;
    logic              top_carry;
    logic              take;

    hkey_swap_shift #(.WORD_W(WORD_W)) u_shift (
        .first_w   (in_first),
        .second_w  (in_second),
        .shl_hi    (shl_hi),
        .shl_lo    (shl_lo),
        .carry_out (top_carry)
    );

    hkey_fold #(
        .WORD_W  (WORD_W),
        .FOLD_HI (FOLD_HI),
        .FOLD_LO (FOLD_LO)
    ) u_fold (
        .val_hi  (shl_hi),
        .val_lo  (shl_lo),
        .fold_en (top_carry),
        .res_hi  (cond_hi),
        .res_lo  (cond_lo)
    );

    assign in_ready = ~rst;
    assign take     = in_valid & in_ready;

    always_comb begin
        state_d      = state_q;
        state_d.done = take;
        if (take) begin
            state_d.hi = cond_hi;
            state_d.lo = cond_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_hi   = state_q.hi;
    assign out_lo   = state_q.lo;
    assign out_done = state_q.done;
endmodule

// File: rtl/hkey_prep_chk.sv
module hkey_prep_chk #(
    parameter int unsigned       WORD_W  = 64,
    parameter logic [WORD_W-1:0] FOLD_HI = '0,
    parameter logic [WORD_W-1:0] FOLD_LO = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [WORD_W-1:0] in_first,
    input logic [WORD_W-1:0] in_second,
    input logic [WORD_W-1:0] out_hi,
    input logic [WORD_W-1:0] out_lo,
    input logic              out_done
);
    // R1: reset clears everything visible
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (out_done == 1'b0 && out_hi == '0 && out_lo == '0));

    // R2: ready whenever out of reset
    a_r2_ready_up: assert property (@(posedge clk) disable iff (rst)
        !rst |-> in_ready);

    // R3: pulse after accept, quiet otherwise
    a_r3_done_after_take: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_done);
    a_r3_no_stray_done: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> !out_done);

    // R4, R5: boundary bit crosses into the upper half
    a_r5_boundary_bit: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=>
        out_hi[0] == ($past(in_second[WORD_W-1]) ^ (FOLD_HI[0] & $past(in_first[WORD_W-1]))));

    // R6, R7: low bit of result equals carry folded through the constant
    a_r6_low_fold_bit: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_lo[0] == (FOLD_LO[0] & $past(in_first[WORD_W-1])));

    // R8: no update without a handshake
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> ($stable(out_hi) && $stable(out_lo)));
endmodule

bind hkey_prep hkey_prep_chk #(
    .WORD_W  (WORD_W),
    .FOLD_HI (FOLD_HI),
    .FOLD_LO (FOLD_LO)
) u_chk (.*);

// File: tb/hkey_prep_test.sv
`timescale 1ns/1ps
module hkey_prep_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [63:0] in_first, in_second;
    logic [63:0] out_hi, out_lo;
    logic        out_done;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    hkey_prep uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_first  (in_first),
        .in_second (in_second),
        .out_hi    (out_hi),
        .out_lo    (out_lo),
        .out_done  (out_done)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] expect_key(input logic [63:0] f, input logic [63:0] s);
        logic [127:0] v;
        v = {f, s} << 1;
        if (f[63]) v = v ^ {64'hC200_0000_0000_0000, 64'h0000_0000_0000_0001};
        return v;
    endfunction

    // drive at negedge, accept on next posedge, sample at following negedge
    task automatic send(input logic [63:0] f, input logic [63:0] s, input string tag);
        logic [127:0] e;
        e = expect_key(f, s);
        in_first  = f;
        in_second = s;
        in_valid  = 1'b1;
        check("R2 ready", {63'd0, in_ready}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " hi"}, out_hi, e[127:64]);
        check({tag, " lo"}, out_lo, e[63:0]);
        check("R3 done pulse", {63'd0, out_done}, 64'd1);
        // idle cycle with scrambled inputs: hold and no pulse
        in_first  = ~f;
        in_second = ~s;
        @(negedge clk);
        check("R3 done drops", {63'd0, out_done}, 64'd0);
        check("R8 hold hi", out_hi, e[127:64]);
        check("R8 hold lo", out_lo, e[63:0]);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] ra, rb;
        rst = 1'b1; in_valid = 1'b0; in_first = '1; in_second = '1;
        repeat (3) @(negedge clk);
        check("R1 reset hi", out_hi, 64'd0);
        check("R1 reset lo", out_lo, 64'd0);
        check("R1 reset done", {63'd0, out_done}, 64'd0);
        check("R2 ready low in reset", {63'd0, in_ready}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R7: plain shift, R4 and R5 through walking ones
        send(64'd0, 64'd0, "R7 zero");
        for (int i = 0; i < 64; i++) send(64'd0, 64'd1 << i, "R5 walk second");
        for (int i = 0; i < 63; i++) send(64'd1 << i, 64'd0, "R4 walk first");
        // R6: carry out of the top
        send(64'h8000_0000_0000_0000, 64'd0, "R6 carry only");
        send('1, '1, "R6 all ones");
        for (int i = 0; i < 64; i++)
            send(64'h8000_0000_0000_0000, 64'd1 << i, "R6 carry walk");
        for (int i = 0; i < 200; i++) begin
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            send(ra, rb, ra[63] ? "R6 random" : "R7 random");
        end

        // R1: reset mid-run clears a loaded key
        send(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, "R4 pattern");
        rst = 1'b1;
        @(negedge clk);
        check("R1 midrun hi", out_hi, 64'd0);
        check("R1 midrun lo", out_lo, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        send(64'hFFFF_0000_FFFF_0000, 64'h0000_FFFF_0000_FFFF, "R7 after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule